// File: doc/BRIEF.md
# Memory command issue scheduler

This block decides the cycle in which the next queued memory command may start on a static-memory timing engine. It sits between the command queue (a valid/ready handshake carrying direction, chip select and burst length) and the timing engine. It remembers the direction and chip select of the last access. It holds a command back while the engine is still working, while a required turnaround gap has not yet elapsed, while the read-data queue lacks room for a whole read burst, or while the external bus is not granted and grant gating is on.

When the block lets a command go, it raises `issue` in the same cycle the queue handshake completes. Alongside it, `issue_cs_release` tells the engine whether chip select must drop before the burst or may stay asserted from the previous one. A programmable cap limits how many bursts in a row may share a held chip select.

The control is a three-state machine:
- ST_EMPTY: no access since reset.
- ST_RUN: the issued command is in the engine.
- ST_OPEN: the engine is idle and a previous access is on record.

The transitions are:
- ST_EMPTY to ST_RUN, on issue.
- ST_RUN to ST_OPEN, when `eng_busy` is sampled low.
- ST_OPEN to ST_RUN, on issue.

The engine must raise `eng_busy` from the cycle after `issue` until its command is done.

Top module: `mem_issue_sched`

## Requirements
- R1: After reset there is no access history. The first command issues in the cycle it is presented, provided the engine is idle and the other gates are open, whatever `cfg_tr` holds. `issue_cs_release` is 1 for that command.
- R2: `issue` is high only when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from the cycle after an issue until the first cycle after `eng_busy` is sampled low.
- R3: A read after a write, a write after a read, or a read after a read to a different chip select needs a turnaround gap. If `eng_busy` is first sampled low in cycle c, such a command issues no earlier than cycle c+1+`cfg_tr`. A `cfg_tr` of 0 adds no delay.
- R4: A write after a write (any chip select) or a read after a read to the same chip select needs no gap and may issue in cycle c+1.
- R5: A read (`cmd_write`=0) waits until `rdq_free` >= `cmd_len`. A write issues whatever `rdq_free` holds.
- R6: When `gnt_gate_en`=1 no command issues while `bus_gnt`=0. When `gnt_gate_en`=0, `bus_gnt` has no effect.
- R7: `issue_cs_release` is 1 when the chip select differs from the previous one or a turnaround gap applies. Otherwise it is 0 unless the cap of R8 is reached.
- R8: With `cfg_cap`=N (1..15), at most N consecutive bursts share a held chip select. The next same-chip burst carries `issue_cs_release`=1 and starts a new run.
- R9: `cfg_cap`=0 removes the limit, so same-chip, same-direction bursts keep chip select held indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command queue has a command |
| cmd_ready | output | 1 | Scheduler accepts the command this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_cs | input | CS_W | Target chip select |
| cmd_len | input | LEN_W | Burst length in beats |
| rdq_free | input | FREE_W | Free entries in the read-data queue |
| eng_busy | input | 1 | Timing engine is executing a command |
| gnt_gate_en | input | 1 | Enable holding off on missing bus grant |
| bus_gnt | input | 1 | External bus granted |
| cfg_tr | input | TR_W | Turnaround gap in cycles |
| cfg_cap | input | CAP_W | Max consecutive bursts with chip select held, 0 = unlimited |
| issue | output | 1 | Start strobe to the timing engine |
| issue_cs_release | output | 1 | Chip select must be released before this burst |

## Verification
The bench measures the exact cycle distance between issues, with and without a turnaround gap. A design that applies the gap to same-chip repeats, skips it for a read to another chip, or is off by one cycle in either case shows up as a wrong distance. Reads are held with `rdq_free` one short of the burst length, so a `>` versus `>=` slip or a check also applied to writes is caught. Runs of same-chip writes under caps of 3, 1 and 0 expose a counter that releases one burst late or early, or that treats 0 as a cap of zero bursts. The first command after reset is sent with the largest gap, which catches a design that waits for turnaround with no history.

// File: rtl/mis_pkg.sv
`timescale 1ns/1ps
package mis_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_RUN   = 2'd1,
        ST_OPEN  = 2'd2
    } mis_state_e;
endpackage

// File: rtl/mis_gap_timer.sv
`timescale 1ns/1ps
// Counts idle cycles since the engine finished; saturates above any gap setting.
module mis_gap_timer #(
    parameter int TR_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic [TR_W-1:0] cfg_tr,
    output logic            gap_met
);
    localparam int CNT_W = TR_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            idle_cnt <= '0;
        end else if (idle_cnt != CNT_MAX) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    assign gap_met = idle_cnt >= CNT_W'(cfg_tr);
endmodule

// File: rtl/mis_burst_cap.sv
`timescale 1ns/1ps
// Length of the current run of bursts sharing a held chip select.
module mis_burst_cap #(
    parameter int CAP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_i,
    input  logic             rel_i,
    input  logic [CAP_W-1:0] cfg_cap,
    output logic             cap_hit
);
    localparam logic [CAP_W-1:0] RUN_MAX = '1;

    logic [CAP_W-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (issue_i) begin
            if (rel_i) begin
                run_cnt <= CAP_W'(1);
            end else if (run_cnt != RUN_MAX) begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    assign cap_hit = (cfg_cap != '0) && (run_cnt >= cfg_cap);
endmodule

// File: rtl/mis_issue_gate.sv
`timescale 1ns/1ps
// Combinational issue conditions: turnaround need, read space, bus grant.
module mis_issue_gate #(
    parameter int CS_W    = 2,
    parameter int LEN_W   = 4,
    parameter int FREE_W  = 5,
    parameter bit HAS_GNT = 1'b1
) (
    input  logic              have_prev,
    input  logic              prev_write,
    input  logic [CS_W-1:0]   prev_cs,
    input  logic              cmd_write,
    input  logic [CS_W-1:0]   cmd_cs,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [FREE_W-1:0] rdq_free,
    input  logic              gnt_gate_en,
    input  logic              bus_gnt,
    output logic              need_turn,
    output logic              cs_change,
    output logic              space_ok,
    output logic              gnt_ok
);
    localparam int CMP_W = (LEN_W > FREE_W) ? LEN_W : FREE_W;

    logic [CMP_W-1:0] len_x;
    logic [CMP_W-1:0] free_x;

    assign len_x     = CMP_W'(cmd_len);
    assign free_x    = CMP_W'(rdq_free);
    assign space_ok  = free_x >= len_x;
    assign cs_change = have_prev && (prev_cs != cmd_cs);
    assign need_turn = have_prev &&
                       ((prev_write != cmd_write) || (!cmd_write && (prev_cs != cmd_cs)));

    generate
        if (HAS_GNT) begin : g_gnt
            assign gnt_ok = !gnt_gate_en || bus_gnt;
        end else begin : g_no_gnt
            logic unused_gnt;
            assign unused_gnt = gnt_gate_en ^ bus_gnt;
            assign gnt_ok     = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/mem_issue_sched.sv
`timescale 1ns/1ps
module mem_issue_sched #(
    parameter int CS_W    = 2,
    parameter int LEN_W   = 4,
    parameter int FREE_W  = 5,
    parameter int TR_W    = 3,
    parameter int CAP_W   = 4,
    parameter bit HAS_GNT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [CS_W-1:0]   cmd_cs,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [FREE_W-1:0] rdq_free,
    input  logic              eng_busy,
    input  logic              gnt_gate_en,
    input  logic              bus_gnt,
    input  logic [TR_W-1:0]   cfg_tr,
    input  logic [CAP_W-1:0]  cfg_cap,
    output logic              issue,
    output logic              issue_cs_release
);
    import mis_pkg::*;

    mis_state_e      state, state_nxt;
    logic            prev_write;
    logic [CS_W-1:0] prev_cs;
    logic            have_prev;
    logic            need_turn, cs_change, space_ok, gnt_ok;
    logic            gap_met, cap_hit;
    logic            slot_open;

    assign have_prev = (state != ST_EMPTY);

    mis_issue_gate #(
        .CS_W(CS_W), .LEN_W(LEN_W), .FREE_W(FREE_W), .HAS_GNT(HAS_GNT)
    ) u_gate (
        .have_prev   (have_prev),
        .prev_write  (prev_write),
        .prev_cs     (prev_cs),
        .cmd_write   (cmd_write),
        .cmd_cs      (cmd_cs),
        .cmd_len     (cmd_len),
        .rdq_free    (rdq_free),
        .gnt_gate_en (gnt_gate_en),
        .bus_gnt     (bus_gnt),
        .need_turn   (need_turn),
        .cs_change   (cs_change),
        .space_ok    (space_ok),
        .gnt_ok      (gnt_ok)
    );

    mis_gap_timer #(.TR_W(TR_W)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state != ST_OPEN),
        .cfg_tr  (cfg_tr),
        .gap_met (gap_met)
    );

    mis_burst_cap #(.CAP_W(CAP_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .issue_i (issue),
        .rel_i   (issue_cs_release),
        .cfg_cap (cfg_cap),
        .cap_hit (cap_hit)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
        end else begin
            state <= state_nxt;
        end
    end

    // Access history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_write <= 1'b0;
            prev_cs    <= '0;
        end else if (issue) begin
            prev_write <= cmd_write;
            prev_cs    <= cmd_cs;
        end
    end

    // Next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_EMPTY: if (issue)     state_nxt = ST_RUN;
            ST_RUN:   if (!eng_busy) state_nxt = ST_OPEN;
            ST_OPEN:  if (issue)     state_nxt = ST_RUN;
            default:                 state_nxt = ST_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        slot_open = 1'b0;
        unique case (state)
            ST_EMPTY: slot_open = 1'b1;
            ST_OPEN:  slot_open = !need_turn || gap_met;
            ST_RUN:   slot_open = 1'b0;
            default:  slot_open = 1'b0;
        endcase
        cmd_ready        = slot_open && !eng_busy && gnt_ok && (cmd_write || space_ok);
        issue            = cmd_valid && cmd_ready;
        issue_cs_release = !have_prev || need_turn || cs_change || cap_hit;
    end
endmodule

// File: rtl/mis_sched_chk.sv
`timescale 1ns/1ps
module mis_sched_chk #(
    parameter int CS_W    = 2,
    parameter int LEN_W   = 4,
    parameter int FREE_W  = 5,
    parameter int TR_W    = 3,
    parameter int CAP_W   = 4,
    parameter bit HAS_GNT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              cmd_write,
    input logic [CS_W-1:0]   cmd_cs,
    input logic [LEN_W-1:0]  cmd_len,
    input logic [FREE_W-1:0] rdq_free,
    input logic              eng_busy,
    input logic              gnt_gate_en,
    input logic              bus_gnt,
    input logic [TR_W-1:0]   cfg_tr,
    input logic [CAP_W-1:0]  cfg_cap,
    input logic              issue,
    input logic              issue_cs_release
);
    localparam int Q_W = TR_W + 1;
    localparam int M_W = (LEN_W > FREE_W) ? LEN_W : FREE_W;

    logic             seen, pw;
    logic [CS_W-1:0]  pcs;
    logic [Q_W-1:0]   quiet;
    logic [CAP_W-1:0] held;
    logic             turn;

    assign turn = (pw != cmd_write) || (!cmd_write && (pcs != cmd_cs));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen  <= 1'b0;
            pw    <= 1'b0;
            pcs   <= '0;
            quiet <= '0;
            held  <= '0;
        end else begin
            if (issue) begin
                seen <= 1'b1;
                pw   <= cmd_write;
                pcs  <= cmd_cs;
                held <= issue_cs_release ? CAP_W'(1) :
                        ((held == '1) ? held : held + 1'b1);
            end
            if (issue || eng_busy) quiet <= '0;
            else if (quiet != '1)  quiet <= quiet + 1'b1;
        end
    end

    AST_FIRST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        issue && !seen |-> issue_cs_release); // R1
    AST_ISSUE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> cmd_valid); // R2
    AST_READY_ENGINE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !eng_busy); // R2
    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> !cmd_ready); // R2
    AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        issue && seen && turn |-> (quiet > Q_W'(cfg_tr))); // R3
    AST_READ_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        issue && !cmd_write |-> (M_W'(rdq_free) >= M_W'(cmd_len))); // R5
    AST_HOLD_SAME_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
        issue && seen && !turn && (pcs == cmd_cs) && ((cfg_cap == '0) || (held < cfg_cap))
        |-> !issue_cs_release); // R7
    AST_CAP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        issue && (cfg_cap != '0) && (held >= cfg_cap) |-> issue_cs_release); // R8

    generate
        if (HAS_GNT) begin : g_gnt_chk
            AST_GRANT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
                issue && gnt_gate_en |-> bus_gnt); // R6
        end
    endgenerate
endmodule

bind mem_issue_sched mis_sched_chk #(
    .CS_W(CS_W), .LEN_W(LEN_W), .FREE_W(FREE_W),
    .TR_W(TR_W), .CAP_W(CAP_W), .HAS_GNT(HAS_GNT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_cs(cmd_cs), .cmd_len(cmd_len), .rdq_free(rdq_free),
    .eng_busy(eng_busy), .gnt_gate_en(gnt_gate_en), .bus_gnt(bus_gnt),
    .cfg_tr(cfg_tr), .cfg_cap(cfg_cap), .issue(issue), .issue_cs_release(issue_cs_release)
);

// File: tb/mem_issue_sched_bench.sv
`timescale 1ns/1ps
module mem_issue_sched_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic       cmd_write = 1'b1;
    logic [1:0] cmd_cs = 2'd0;
    logic [3:0] cmd_len = 4'd1;
    logic [4:0] rdq_free = 5'd16;
    logic       eng_busy;
    logic       gnt_gate_en = 1'b0;
    logic       bus_gnt = 1'b0;
    logic [2:0] cfg_tr = 3'd0;
    logic [3:0] cfg_cap = 4'd0;
    logic       issue;
    logic       issue_cs_release;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int last_iss = 0;
    int eng_dur  = 2;
    int busy_cnt = 0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (issue) busy_cnt <= eng_dur;
        else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    end
    assign eng_busy = (busy_cnt != 0);

    mem_issue_sched u_mem_issue_sched (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_write(cmd_write), .cmd_cs(cmd_cs), .cmd_len(cmd_len), .rdq_free(rdq_free),
        .eng_busy(eng_busy), .gnt_gate_en(gnt_gate_en), .bus_gnt(bus_gnt),
        .cfg_tr(cfg_tr), .cfg_cap(cfg_cap), .issue(issue), .issue_cs_release(issue_cs_release)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present a command at a falling edge and wait for its issue.
    task automatic send(input logic w, input logic [1:0] cs, input logic [3:0] len,
                        output int delta, output int rel, output int waited);
        int guard = 0;
        int early = 0;
        cmd_write = w; cmd_cs = cs; cmd_len = len; cmd_valid = 1'b1;
        #1;
        while (!issue && guard < 300) begin
            if (cmd_ready && (cyc - last_iss) <= eng_dur + 1) early++;
            @(negedge clk); #1;
            guard++;
        end
        chk("R2 ready low while engine in flight", early, 0);
        if (guard >= 300) chk("R2 command never issued", 0, 1);
        waited   = guard;
        delta    = cyc - last_iss;
        rel      = int'(issue_cs_release);
        last_iss = cyc;
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Present a command and confirm it does not issue for n cycles.
    task automatic present_hold(input string req, input logic w, input logic [1:0] cs,
                                input logic [3:0] len, input int n);
        int bad = 0;
        cmd_write = w; cmd_cs = cs; cmd_len = len; cmd_valid = 1'b1;
        for (int i = 0; i < n; i++) begin
            #1;
            if (issue) bad++;
            @(negedge clk);
        end
        chk(req, bad, 0);
    endtask

    task automatic finish_issue(input string req);
        #1;
        chk(req, int'(issue), 1);
        if (issue) last_iss = cyc;
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic t_reset_first();
        int d, r, wt;
        #1;
        chk("R1 issue low after reset", int'(issue), 0);
        chk("R1 ready after reset", int'(cmd_ready), 1);
        cfg_tr = 3'd7;
        send(1'b1, 2'd0, 4'd1, d, r, wt);
        chk("R1 first command waits no cycles", wt, 0);
        chk("R1 first command releases cs", r, 1);
    endtask

    task automatic t_turnaround();
        int d, r, wt;
        cfg_tr = 3'd3;
        send(1'b1, 2'd0, 4'd1, d, r, wt);          // write after write, same cs
        chk("R4 write-write same cs spacing", d, eng_dur + 2);
        chk("R7 write-write same cs holds cs", r, 0);
        send(1'b0, 2'd0, 4'd4, d, r, wt);          // read after write
        chk("R3 read after write gap", d, eng_dur + 2 + 3);
        chk("R7 direction change releases cs", r, 1);
        send(1'b0, 2'd1, 4'd4, d, r, wt);          // read after read, other cs
        chk("R3 read after read other cs gap", d, eng_dur + 2 + 3);
        send(1'b0, 2'd1, 4'd4, d, r, wt);          // read after read, same cs
        chk("R4 read-read same cs spacing", d, eng_dur + 2);
        chk("R7 read-read same cs holds cs", r, 0);
        send(1'b1, 2'd1, 4'd1, d, r, wt);          // write after read
        chk("R3 write after read gap", d, eng_dur + 2 + 3);
        send(1'b1, 2'd2, 4'd1, d, r, wt);          // write after write, other cs
        chk("R4 write-write other cs spacing", d, eng_dur + 2);
        chk("R7 cs change releases cs", r, 1);
        cfg_tr = 3'd0;
        send(1'b0, 2'd2, 4'd2, d, r, wt);
        chk("R3 zero gap read after write", d, eng_dur + 2);
    endtask

    task automatic t_space();
        int d, r, wt;
        rdq_free = 5'd7;
        present_hold("R5 read held with space one short", 1'b0, 2'd2, 4'd8, 12);
        rdq_free = 5'd8;
        finish_issue("R5 read issues when space equals length");
        rdq_free = 5'd0;
        send(1'b1, 2'd2, 4'd1, d, r, wt);
        chk("R5 write ignores read space", d, eng_dur + 2);
        rdq_free = 5'd16;
    endtask

    task automatic t_grant();
        int d, r, wt;
        gnt_gate_en = 1'b1; bus_gnt = 1'b0;
        present_hold("R6 held without grant", 1'b1, 2'd2, 4'd1, 10);
        bus_gnt = 1'b1;
        finish_issue("R6 issues once granted");
        gnt_gate_en = 1'b0; bus_gnt = 1'b0;
        send(1'b1, 2'd2, 4'd1, d, r, wt);
        chk("R6 grant ignored when gating off", d, eng_dur + 2);
    endtask

    task automatic t_cap();
        int d, r, wt;
        int exp3 [5] = '{1, 0, 0, 1, 0};
        cfg_cap = 4'd3;
        for (int i = 0; i < 5; i++) begin
            send(1'b1, 2'd3, 4'd1, d, r, wt);
            chk($sformatf("R8 cap 3 burst %0d release", i), r, exp3[i]);
        end
        cfg_cap = 4'd0;
        send(1'b1, 2'd1, 4'd1, d, r, wt);
        chk("R9 new cs releases", r, 1);
        for (int i = 0; i < 5; i++) begin
            send(1'b1, 2'd1, 4'd1, d, r, wt);
            chk($sformatf("R9 unlimited burst %0d holds", i), r, 0);
        end
        cfg_cap = 4'd1;
        for (int i = 0; i < 3; i++) begin
            send(1'b1, 2'd1, 4'd1, d, r, wt);
            chk($sformatf("R8 cap 1 burst %0d release", i), r, 1);
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset_first();
        t_turnaround();
        t_space();
        t_grant();
        t_cap();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule